// File: doc/BRIEF.md
# SONET A1/A2 Frame Aligner

This block sits behind a serial receiver and turns a raw bit stream into framed bytes. One bit arrives per clock, with the most significant bit of each byte first. The bits run through a 48-bit window that is compared on every clock against three A1 bytes (8'hF6) followed by three A2 bytes (8'h28). The check covers every bit offset. Between realignments, a free-running boundary counter slices the stream into bytes. Each byte is presented with a one-clock strobe.

Hunting is controlled by a level-sensitive out-of-frame request. While the request is high, every occurrence of the pattern reloads the boundary counter, so the third A2 byte appears on the output at once. A frame pulse lasting one byte period goes out with that byte. While the request is low, the pattern is ignored and the current boundary is kept. Upstream logic typically raises the request on loss of frame and drops it once framing is confirmed.

Top module: `a1a2_aligner`

## Requirements
- R1: While reset is asserted and immediately after it is released, par_byte is 0, byte_stb is 0 and frame_pulse is 0. The first byte_stb comes on the 8th rising clock edge after release.
- R2: At each byte_stb, par_byte holds the 8 most recently received bits. The earliest of them is in bit 7 and the latest in bit 0. par_byte keeps its value between strobes.
- R3: Suppose the 48 most recently received bits equal 8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28 in arrival order, and oof_req is high on the next rising edge. Then on that edge byte_stb rises and par_byte becomes 8'h28, the third A2 byte.
- R4: frame_pulse rises together with the strobe that carries the third A2 byte. It stays high for exactly one byte period and falls at the next byte_stb.
- R5: While oof_req is low, a pattern occurrence produces no frame_pulse and does not move the byte boundary.
- R6: byte_stb is high for one clock in every 8 clocks when no realignment occurs. After a realignment, the next strobe comes 8 clocks after the realigning strobe.
- R7: While oof_req stays high, each later pattern occurrence realigns again and produces another frame_pulse. This holds at the same offset or at a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Serial data bit, MSB of each byte first |
| oof_req | input | 1 | Out-of-frame level; high enables hunting and realignment |
| par_byte | output | 8 | Byte-aligned parallel data |
| byte_stb | output | 1 | One-clock strobe marking a new par_byte |
| frame_pulse | output | 1 | High for one byte period with the third A2 byte |

## Verification
A corrupted window register or a wrong slot comparison shows up as a missed or spurious frame_pulse. It appears at most one clock after the final A2 bit, and par_byte then differs from 8'h28. A boundary counter that drifts or fails to reload shows up within 8 clocks as a strobe in the wrong cycle. It also yields bytes taken from the wrong bit offset. An out-of-frame gate that leaks lets a pattern sent with the request low move the strobe phase, and this is visible at the next strobe.

// File: rtl/fa_pkg.sv
package fa_pkg;
   localparam int unsigned FA_BYTE_W  = 8;
   localparam logic [7:0]  FA_A1_DEF  = 8'hF6;
   localparam logic [7:0]  FA_A2_DEF  = 8'h28;
   localparam int unsigned FA_RUN_DEF = 3;
endpackage

// File: rtl/fa_pattern_match.sv
module fa_pattern_match #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned RUN    = 3,
   parameter logic [BYTE_W-1:0] A1 = 8'hF6,
   parameter logic [BYTE_W-1:0] A2 = 8'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   output logic [BYTE_W-1:0] last_byte,
   output logic              hit
);
   localparam int unsigned SLOTS = 2 * RUN;
   localparam int unsigned WIN_W = SLOTS * BYTE_W;

   logic [WIN_W-1:0] window;
   logic [SLOTS-1:0] slot_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) window <= '0;
      else        window <= {window[WIN_W-2:0], ser_bit};
   end

   // Slot 0 holds the newest byte; the first RUN slots expect A2, the rest A1.
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s < RUN) begin : g_a2
         assign slot_ok[s] = (window[s*BYTE_W +: BYTE_W] == A2);
      end else begin : g_a1
         assign slot_ok[s] = (window[s*BYTE_W +: BYTE_W] == A1);
      end
   end

   assign hit       = &slot_ok;
   assign last_byte = window[BYTE_W-1:0];
endmodule

// File: rtl/fa_boundary_ctr.sv
module fa_boundary_ctr #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic realign,
   output logic load
);
   localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0] phase;

   assign load = realign | (phase == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase <= '0;
      else if (load) phase <= '0;
      else           phase <= phase + 1'b1;
   end
endmodule

// File: rtl/fa_byte_out.sv
module fa_byte_out #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              frame,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout,
   output logic              stb,
   output logic              fp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         stb  <= 1'b0;
         fp   <= 1'b0;
      end else if (load) begin
         dout <= din;
         stb  <= 1'b1;
         fp   <= frame;
      end else begin
         stb  <= 1'b0;
      end
   end
endmodule

// File: rtl/a1a2_aligner.sv
module a1a2_aligner
   import fa_pkg::*;
#(
   parameter int unsigned BYTE_W = FA_BYTE_W,
   parameter int unsigned RUN    = FA_RUN_DEF,
   parameter logic [BYTE_W-1:0] A1 = FA_A1_DEF,
   parameter logic [BYTE_W-1:0] A2 = FA_A2_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              oof_req,
   output logic [BYTE_W-1:0] par_byte,
   output logic              byte_stb,
   output logic              frame_pulse
);
   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_width
      $error("BYTE_W must be a power of two of at least 2");
   end
   if (RUN < 1 || RUN > 16) begin : g_bad_run
      $error("RUN must lie between 1 and 16");
   end

   logic [BYTE_W-1:0] newest;
   logic              hit;
   logic              realign;
   logic              load;

   fa_pattern_match #(.BYTE_W(BYTE_W), .RUN(RUN), .A1(A1), .A2(A2)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_bit   (ser_bit),
      .last_byte (newest),
      .hit       (hit)
   );

   assign realign = hit & oof_req;

   fa_boundary_ctr #(.BYTE_W(BYTE_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .realign (realign),
      .load    (load)
   );

   fa_byte_out #(.BYTE_W(BYTE_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .frame (realign),
      .din   (newest),
      .dout  (par_byte),
      .stb   (byte_stb),
      .fp    (frame_pulse)
   );
endmodule

// File: rtl/fa_aligner_chk.sv
module fa_aligner_chk #(
   parameter int unsigned BYTE_W = 8,
   parameter logic [BYTE_W-1:0] A2 = 8'h28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              oof_req,
   input logic [BYTE_W-1:0] par_byte,
   input logic              byte_stb,
   input logic              frame_pulse
);
   localparam int unsigned GAP_W = $clog2(BYTE_W) + 2;
   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap <= '0;
      else if (byte_stb) gap <= '0;
      else               gap <= gap + 1'b1;
   end

   assert_third_a2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_pulse) |-> par_byte == A2);

   assert_pulse_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_pulse) |-> byte_stb);

   assert_pulse_ends_at_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_pulse) |-> byte_stb);

   assert_no_pulse_when_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_pulse) |-> $past(oof_req));

   assert_strobe_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gap >= GAP_W'(BYTE_W)) |-> byte_stb);
endmodule

bind a1a2_aligner fa_aligner_chk #(.BYTE_W(BYTE_W), .A2(A2)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .oof_req     (oof_req),
   .par_byte    (par_byte),
   .byte_stb    (byte_stb),
   .frame_pulse (frame_pulse)
);

// File: tb/test_a1a2_aligner.sv
module test_a1a2_aligner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_bit = 1'b0;
   logic       oof_req = 1'b0;
   logic [7:0] par_byte;
   logic       byte_stb;
   logic       frame_pulse;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;
   bit done    = 0;

   localparam logic [47:0] PAT = {8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28};

   a1a2_aligner i_a1a2_aligner (
      .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .oof_req(oof_req),
      .par_byte(par_byte), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
   );

   always #10 clk = ~clk;

   // Behavioural reference model
   bit         hist[$];
   int         since;
   logic [7:0] m_byte;
   logic       m_stb;
   logic       m_fp;
   int         fp_rises;
   logic       prev_fp;

   function automatic bit age(int j);
      if (j < hist.size()) return hist[hist.size() - 1 - j];
      return 1'b0;
   endfunction

   function automatic bit pat_seen();
      if (hist.size() < 48) return 1'b0;
      for (int j = 0; j < 48; j++) if (age(j) != PAT[j]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [7:0] newest8();
      logic [7:0] b;
      for (int j = 0; j < 8; j++) b[j] = age(j);
      return b;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist.delete();
         since = 0; m_byte = 8'h00; m_stb = 1'b0; m_fp = 1'b0;
      end else begin
         if (oof_req && pat_seen()) begin
            m_byte = newest8(); m_stb = 1'b1; m_fp = 1'b1; since = 0;
         end else if (since == 7) begin
            m_byte = newest8(); m_stb = 1'b1; m_fp = 1'b0; since = 0;
         end else begin
            m_stb = 1'b0; since++;
         end
         hist.push_back(ser_bit);
         if (hist.size() > 64) void'(hist.pop_front());
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(byte_stb === m_stb, "R6", "byte_stb", byte_stb, m_stb);
         check(par_byte === m_byte, "R2", "par_byte", par_byte, m_byte);
         check(frame_pulse === m_fp, "R4", "frame_pulse", frame_pulse, m_fp);
         if (frame_pulse === 1'b1 && prev_fp !== 1'b1) fp_rises++;
         prev_fp = frame_pulse;
      end
   end

   task automatic send_bit(bit b, bit oof);
      @(negedge clk);
      ser_bit = b; oof_req = oof;
   endtask

   task automatic send_byte(logic [7:0] b, bit oof);
      for (int k = 7; k >= 0; k--) send_bit(b[k], oof);
   endtask

   task automatic send_junk(int nbits, bit oof);
      for (int k = 0; k < nbits; k++) send_bit(1'($urandom_range(0, 1)), oof);
   endtask

   task automatic send_frame(bit oof);
      for (int k = 0; k < 3; k++) send_byte(8'hF6, oof);
      for (int k = 0; k < 3; k++) send_byte(8'h28, oof);
   endtask

   task automatic expect_rises(int exp, string req);
      check(fp_rises == exp, req, "frame pulse count", fp_rises, exp);
      fp_rises = 0;
   endtask

   initial begin
      fp_rises = 0; prev_fp = 1'b0;
      void'($urandom(17));
      repeat (4) @(negedge clk);
      // R1: reset state at the ports
      check(par_byte === 8'h00 && byte_stb === 1'b0 && frame_pulse === 1'b0,
            "R1", "reset outputs", {par_byte, byte_stb, frame_pulse}, 0);
      rst_n = 1'b1;
      send_junk(20, 1'b0);
      expect_rises(0, "R1");

      // R5: pattern with out-of-frame low is ignored
      send_junk(3, 1'b0);
      send_frame(1'b0);
      send_junk(80, 1'b0);
      expect_rises(0, "R5");

      // R3/R4: hunting enabled, pattern at a fresh offset
      send_junk(5, 1'b1);
      send_junk(32, 1'b1);
      send_frame(1'b1);
      send_junk(24, 1'b1);
      expect_rises(1, "R3");

      // R7: still out of frame, new offset realigns again
      send_junk(2, 1'b1);
      send_frame(1'b1);
      send_junk(24, 1'b1);
      expect_rises(1, "R7");

      // R7: back-to-back frames at the same offset
      send_frame(1'b1);
      send_frame(1'b1);
      send_junk(16, 1'b1);
      expect_rises(2, "R7");

      // R5: in frame again, another offset must not move the boundary
      send_junk(6, 1'b0);
      send_frame(1'b0);
      send_junk(40, 1'b0);
      expect_rises(0, "R5");

      // R6: long random run, strobe cadence checked every clock
      send_junk(400, 1'b0);
      expect_rises(0, "R6");

      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         vectors++; misses++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule